// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block watches a running clock/calendar value and compares it against two alarm settings. Each alarm chooses, by a match-enable mask, which of eight time fields must agree with the clock: seconds units, seconds tens, minutes units, minutes tens, hour, day, month and day of week. The comparison is made only on the once-per-second tick. An alarm fires on the tick where its enabled fields first become equal, so an alarm that stays equal for several seconds produces only one event.

In latched mode each alarm event sets a sticky status flag. The active-low interrupt output is asserted while a flag is set and that alarm's interrupt enable is also set. The host clears both flags with a status-read strobe, which releases the interrupt line. In pulsed mode alarm 0 no longer uses its flag or enable. Each alarm 0 event drives the interrupt line low for a fixed number of oscillator cycles, which gives a repeating trigger with no processor involved. Alarm 1 still sets its flag in pulsed mode but never drives the line, so the host has to poll it. The timekeeping counters and the serial host interface are outside this block.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The time word is packed from bit 0 upward as seconds units (4 bits BCD), seconds tens (3), minutes units (4), minutes tens (3), hour (6, BCD), day (6, BCD), month (5, BCD), day of week (3). Mask bit i enables the comparison of field i in that same order. A field whose mask bit is clear always counts as matching, and a mismatch in any enabled field blocks the alarm.
- R2: An alarm whose mask is all zero never fires.
- R3: Comparison happens only on a cycle where `tick_1hz` is high. An alarm fires on the tick where its enabled fields become equal, provided they were not equal on the previous tick. It fires again only after a tick with no match.
- R4: In latched mode (`pulse_mode`=0), an alarm event sets that alarm's flag whether or not its interrupt enable is set. The flag can be seen on the outputs two clock edges after the edge that samples the tick.
- R5: In latched mode, `irq_n` is low exactly when (`flag0` and `irq_en0`) or (`flag1` and `irq_en1`). A set flag whose enable is clear leaves `irq_n` high.
- R6: A one-cycle `status_clr` clears both flags at the next edge, and `irq_n` then returns high. If a flag-setting event arrives on the same edge as the clear, the flag ends up set.
- R7: In pulsed mode, an alarm 0 event does not set `flag0`, and the enables are ignored. The event drives `irq_n` low for exactly PULSE_LEN `osc_tick` strobes (default 1024), beginning two edges after the tick edge.
- R8: In pulsed mode, an alarm 1 event sets `flag1` but never pulls `irq_n` low, even with both enables set.
- R9: A new alarm 0 event during a pulse restarts the pulse at its full length, and `irq_n` stays low in between.
- R10: The pulse counter advances only on cycles where `osc_tick` is high, so a half-rate strobe doubles the pulse length in clock cycles.
- R11: After reset both flags are clear and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| status_clr | input | 1 | Clears both flags (issued on a status read) |
| pulse_mode | input | 1 | 0 = latched mode, 1 = pulsed alarm 0 |
| irq_en0 | input | 1 | Interrupt enable for alarm 0 (latched mode) |
| irq_en1 | input | 1 | Interrupt enable for alarm 1 (latched mode) |
| now_time | input | 34 | Current packed time fields |
| alm0_time | input | 34 | Alarm 0 packed compare value |
| alm1_time | input | 34 | Alarm 1 packed compare value |
| alm0_mask | input | 8 | Alarm 0 field match enables |
| alm1_mask | input | 8 | Alarm 1 field match enables |
| irq_n | output | 1 | Active-low interrupt / pulse output |
| flag0 | output | 1 | Alarm 0 sticky status flag |
| flag1 | output | 1 | Alarm 1 sticky status flag |

## Verification
The match stage registers each event on the edge that samples the tick. The flag or pulse counter takes it up on the next edge, so flags and the start of a pulse are due two edges after the tick edge. A clear takes effect one edge after it is sampled. The tick task raises the tick on a falling edge and lowers it on the next one, then waits one more falling edge before the results are read, so every check samples after both registers have updated. Pulse width is found by counting falling edges with `irq_n` low from that first sample point, and the count is compared against PULSE_LEN strobes.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NFIELD = 8;
    // field widths, LSB first: sec units, sec tens, min units, min tens, hour, day, month, dow
    localparam int FW [NFIELD] = '{4, 3, 4, 3, 6, 6, 5, 3};

    function automatic int fld_lo(input int idx);
        int s;
        s = 0;
        for (int k = 0; k < idx; k++) s += FW[k];
        return s;
    endfunction

    localparam int TIME_W = fld_lo(NFIELD);
endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] alm_time,
    input  logic [NFIELD-1:0] mask,
    output logic              hit
);
    typedef struct packed {
        logic prev;
        logic hit;
    } match_st_t;

    match_st_t st_d, st_q;
    logic [NFIELD-1:0] fld_eq;
    logic all_eq;

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        localparam int LO = fld_lo(i);
        localparam int W  = FW[i];
        assign fld_eq[i] = !mask[i] || (now_time[LO +: W] == alm_time[LO +: W]);
    end

    assign all_eq = (&fld_eq) && (|mask);

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        if (tick) begin
            st_d.prev = all_eq;
            st_d.hit  = all_eq && !st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.hit;

    // an event only follows a sampled tick
    assert_hit_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(tick));
    // an event needs at least one enabled field
    assert_empty_mask_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(mask) != '0));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int PULSE_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic osc_tick,
    output logic active
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)
            st_d.cnt = CW'(PULSE_LEN);
        else if (osc_tick && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

    assert_restart_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.cnt == CW'(PULSE_LEN)));
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PULSE_LEN));
    assert_hold_without_osc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !start) |=> $stable(st_q.cnt));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_pkg::*;
#(
    parameter int PULSE_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              osc_tick,
    input  logic              status_clr,
    input  logic              pulse_mode,
    input  logic              irq_en0,
    input  logic              irq_en1,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] alm0_time,
    input  logic [TIME_W-1:0] alm1_time,
    input  logic [NFIELD-1:0] alm0_mask,
    input  logic [NFIELD-1:0] alm1_mask,
    output logic              irq_n,
    output logic              flag0,
    output logic              flag1
);
    localparam int NALM = 2;

    typedef struct packed {
        logic f0;
        logic f1;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [NALM-1:0]             hit;
    logic [NALM-1:0][TIME_W-1:0] alm_t;
    logic [NALM-1:0][NFIELD-1:0] alm_m;
    logic pulse_start, pulse_active;

    assign alm_t = {alm1_time, alm0_time};
    assign alm_m = {alm1_mask, alm0_mask};

    for (genvar a = 0; a < NALM; a++) begin : g_alm
        alarm_match u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_1hz),
            .now_time (now_time),
            .alm_time (alm_t[a]),
            .mask     (alm_m[a]),
            .hit      (hit[a])
        );
    end

    assign pulse_start = pulse_mode && hit[0];

    pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pulse_start),
        .osc_tick (osc_tick),
        .active   (pulse_active)
    );

    always_comb begin
        st_d    = st_q;
        st_d.f0 = (st_q.f0 && !status_clr) || (hit[0] && !pulse_mode);
        st_d.f1 = (st_q.f1 && !status_clr) || hit[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag0 = st_q.f0;
    assign flag1 = st_q.f1;
    assign irq_n = pulse_mode ? !pulse_active
                              : !((st_q.f0 && irq_en0) || (st_q.f1 && irq_en1));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && !pulse_mode) |=> flag0);
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && hit == '0) |=> (!flag0 && !flag1));
    assert_pulsed_no_flag0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && !flag0) |=> !flag0);
    assert_pulsed_flag1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> flag1);
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
    import alarm_pkg::*;

    localparam int PLEN = 1024;

    logic clk = 0, rst_n = 0, tick_1hz = 0, osc_tick = 1, status_clr = 0;
    logic pulse_mode = 0, irq_en0 = 0, irq_en1 = 0, osc_half = 0;
    logic [TIME_W-1:0] now_time = '0, alm0_time = '0, alm1_time = '0;
    logic [NFIELD-1:0] alm0_mask = '0, alm1_mask = '0;
    logic irq_n, flag0, flag1;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    always @(negedge clk) osc_tick <= osc_half ? ~osc_tick : 1'b1;

    alarm_irq_ctrl #(.PULSE_LEN(PLEN)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_tick(osc_tick),
        .status_clr(status_clr), .pulse_mode(pulse_mode), .irq_en0(irq_en0),
        .irq_en1(irq_en1), .now_time(now_time), .alm0_time(alm0_time),
        .alm1_time(alm1_time), .alm0_mask(alm0_mask), .alm1_mask(alm1_mask),
        .irq_n(irq_n), .flag0(flag0), .flag1(flag1)
    );

    function automatic logic [TIME_W-1:0] mk_time(int s, int m, int h, int d, int mo, int w);
        return {3'(w), 1'(mo / 10), 4'(mo % 10), 2'(d / 10), 4'(d % 10),
                2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        tick_1hz = 0; status_clr = 0; pulse_mode = 0; irq_en0 = 0; irq_en1 = 0;
        osc_half = 0; alm0_mask = '0; alm1_mask = '0;
        @(negedge clk) rst_n = 1;
        @(negedge clk);
    endtask

    task automatic do_tick(input logic [TIME_W-1:0] t);
        @(negedge clk) begin now_time = t; tick_1hz = 1; end
        @(negedge clk) tick_1hz = 0;
        @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk) status_clr = 1;
        @(negedge clk) status_clr = 0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!irq_n && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_R11();
        do_reset();
        chk("R11 flag0", int'(flag0), 0);
        chk("R11 flag1", int'(flag1), 0);
        chk("R11 irq_n", int'(irq_n), 1);
    endtask

    task automatic t_mask_R1();
        do_reset();
        alm0_time = mk_time(30, 15, 8, 1, 1, 1);
        alm0_mask = 8'b0000_0011;
        alm1_time = mk_time(30, 15, 8, 1, 1, 1);
        alm1_mask = 8'b0000_0111;
        do_tick(mk_time(30, 42, 23, 12, 11, 5));
        chk("R1 masked fields ignored, flag0", int'(flag0), 1);
        chk("R1 enabled minute mismatch, flag1", int'(flag1), 0);
        do_reset();
        alm1_time = mk_time(0, 0, 0, 0, 0, 6);
        alm1_mask = 8'b1000_0000;
        do_tick(mk_time(59, 59, 23, 31, 12, 6));
        chk("R1 day-of-week only, flag1", int'(flag1), 1);
    endtask

    task automatic t_empty_R2();
        do_reset();
        alm0_time = '0; alm1_time = '0;
        do_tick('0);
        do_tick('0);
        chk("R2 empty mask flag0", int'(flag0), 0);
        chk("R2 empty mask flag1", int'(flag1), 0);
    endtask

    task automatic t_edge_R3();
        do_reset();
        alm0_time = mk_time(5, 0, 0, 0, 0, 0);
        alm0_mask = 8'b0000_0011;
        @(negedge clk) now_time = mk_time(5, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R3 no tick no event", int'(flag0), 0);
        do_tick(mk_time(5, 0, 0, 0, 0, 0));
        chk("R3 first equal tick", int'(flag0), 1);
        do_clear();
        do_tick(mk_time(5, 1, 0, 0, 0, 0));
        chk("R3 still equal no re-fire", int'(flag0), 0);
        do_tick(mk_time(6, 1, 0, 0, 0, 0));
        do_tick(mk_time(5, 2, 0, 0, 0, 0));
        chk("R3 re-fire after miss", int'(flag0), 1);
    endtask

    task automatic t_latched_R4_R5();
        do_reset();
        alm0_time = mk_time(10, 0, 0, 0, 0, 0); alm0_mask = 8'h03;
        alm1_time = mk_time(20, 0, 0, 0, 0, 0); alm1_mask = 8'h03;
        do_tick(mk_time(10, 0, 0, 0, 0, 0));
        chk("R4 flag0 set with enable clear", int'(flag0), 1);
        chk("R5 irq_n high while enable clear", int'(irq_n), 1);
        @(negedge clk) irq_en1 = 1;
        #1 chk("R5 other enable does not assert", int'(irq_n), 1);
        @(negedge clk) irq_en0 = 1;
        #1 chk("R5 irq_n low with flag0 and enable", int'(irq_n), 0);
        do_clear();
        chk("R6 clear flag0", int'(flag0), 0);
        chk("R6 irq_n released", int'(irq_n), 1);
        do_tick(mk_time(20, 0, 0, 0, 0, 0));
        chk("R4 flag1 set", int'(flag1), 1);
        chk("R5 irq_n low via alarm 1", int'(irq_n), 0);
    endtask

    task automatic t_clear_race_R6();
        do_reset();
        alm0_time = mk_time(40, 0, 0, 0, 0, 0); alm0_mask = 8'h03;
        @(negedge clk) begin now_time = mk_time(40, 0, 0, 0, 0, 0); tick_1hz = 1; end
        @(negedge clk) begin tick_1hz = 0; status_clr = 1; end
        @(negedge clk) status_clr = 0;
        chk("R6 set wins over clear", int'(flag0), 1);
    endtask

    task automatic t_pulse_R7_R8();
        int n;
        do_reset();
        pulse_mode = 1; irq_en0 = 1; irq_en1 = 1;
        alm1_time = mk_time(33, 0, 0, 0, 0, 0); alm1_mask = 8'h03;
        do_tick(mk_time(33, 0, 0, 0, 0, 0));
        chk("R8 flag1 set in pulsed mode", int'(flag1), 1);
        chk("R8 flag1 does not drive irq_n", int'(irq_n), 1);
        alm0_time = mk_time(44, 0, 0, 0, 0, 0); alm0_mask = 8'h03;
        do_tick(mk_time(44, 0, 0, 0, 0, 0));
        chk("R7 flag0 unused in pulsed mode", int'(flag0), 0);
        count_low(n);
        chk("R7 pulse length", n, PLEN);
        chk("R7 irq_n high after pulse", int'(irq_n), 1);
    endtask

    task automatic t_retrigger_R9();
        int n;
        do_reset();
        pulse_mode = 1;
        alm0_time = mk_time(12, 0, 0, 0, 0, 0); alm0_mask = 8'h03;
        do_tick(mk_time(12, 0, 0, 0, 0, 0));
        repeat (500) @(negedge clk);
        do_tick(mk_time(13, 0, 0, 0, 0, 0));
        chk("R9 still low before retrigger", int'(irq_n), 0);
        do_tick(mk_time(12, 0, 0, 0, 0, 0));
        count_low(n);
        chk("R9 full length after retrigger", n, PLEN);
    endtask

    task automatic t_osc_R10();
        int n;
        do_reset();
        pulse_mode = 1; osc_half = 1;
        alm0_time = mk_time(7, 0, 0, 0, 0, 0); alm0_mask = 8'h03;
        do_tick(mk_time(7, 0, 0, 0, 0, 0));
        count_low(n);
        chk("R10 half-rate strobe stretches pulse", int'(n >= 2*PLEN-2 && n <= 2*PLEN+1), 1);
        if (n < 2*PLEN-2 || n > 2*PLEN+1) $display("  R10 measured %0d cycles", n);
        osc_half = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_R11();
        t_mask_R1();
        t_empty_R2();
        t_edge_R3();
        t_latched_R4_R5();
        t_clear_race_R6();
        t_pulse_R7_R8();
        t_retrigger_R9();
        t_osc_R10();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule